// File: doc/BRIEF.md
# Two-Wire Serial Configuration Register Slave

This block is the slave side of a two-wire serial configuration bus. An external master drives the serial clock and shares an open-drain data line with the block. The block watches both lines with its own system clock and spots start and stop conditions. It answers only to its own 7-bit device address. Through the bus it gives access to a bank of 16-bit configuration words, selected by an 8-bit register address.

A write transaction carries the device address with the direction bit clear, then a register address byte, then one or more 16-bit words sent high byte first. A read transaction first sets the register address with a short write. It then sends a repeated start and the device address with the direction bit set. The block returns words high byte first, and the master acknowledges each byte it wants followed by another. The register pointer advances after every complete word, so a run of words can be written or read in one transaction. Word 0 is an identification value and is read-only, as are any other words marked in a parameter mask. The whole bank is presented in parallel on `cfg_o` for the surrounding logic.

The data line is never driven high. The block pulls it low by raising `sda_oe`, and outside logic turns that into an open-drain pad. The bus has no streaming payload, so every pin is a plain level signal and there is no back-pressure. The master paces each transfer through the serial clock, and the block has no means of slowing it.

Top module: `i2c16_regslave`

## Requirements
- R1: A fall of the data line while the clock is high is a start. It resets the byte machine to expect a device address, and this holds in the middle of a transaction too, where a partly sent word is dropped. The line is released in the cycle after a start is detected.
- R2: The first byte after a start is the 7-bit device address in bits 7..1, sent most significant bit first, with the direction bit in bit 0 (0 = write, 1 = read). If the address does not equal `DEV_ADDR`, the block acknowledges nothing and leaves the line alone until the next start.
- R3: After each byte the block receives in an addressed transaction, it pulls the data line low for the whole ninth clock. This acknowledge is sampled while the clock is high.
- R4: In a write, the byte after the device address is the register address. The next two bytes are a data word, high byte then low byte, and the word appears on `cfg_o[16*k +: 16]` for register k after its low byte.
- R5: Writes to read-only registers have no effect, though they are still acknowledged. Register k is read-only when `RO_MASK[k]` is 1. With the defaults, register 0 always reads `ID_VALUE` (0x1801) and register 1 always reads 0x01FE.
- R6: A read returns the word at the register pointer, high byte first and most significant bit first. The low byte comes from the same word that supplied the high byte.
- R7: The register pointer increments by one after every complete 16-bit word, both written and read, so that consecutive words go to consecutive registers.
- R8: In a read, a master not-acknowledge (data line high during the ninth clock) ends the transfer. The block drives nothing more until the next start.
- R9: A rise of the data line while the clock is high is a stop. It releases the line and ends the transaction, and a word cut off by a stop after its high byte is not written.
- R10: After reset, register 0 holds `ID_VALUE` and every other register k holds {k[7:0], ~k[7:0]}. Register addresses at or above `NUM_REGS` read as 0x0000 and ignore writes.
- R11: `sda_oe` changes only while the synchronized serial clock is low, so the block never creates a start or stop of its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the master |
| sda_i | input | 1 | Value seen on the shared data line |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| cfg_o | output | 16*NUM_REGS | All configuration words, register k in bits 16*k+15..16*k |

## Verification
The bench uses the default parameters: eight registers, with registers 0 and 1 read-only, device address 0x5D and a two-stage synchronizer. With eight registers, the register addresses from 8 upward can be reached, so reads and writes outside the bank can be tested. With two read-only words, both the identification value and a plain protected default can be checked. The serial clock runs at ten system cycles per half period. That leaves room for the synchronizer and register delays, so the bench can test that the data line only moves while the clock is low.

// File: rtl/i2c16_pkg.sv
package i2c16_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } link_st_t;

  typedef enum logic [1:0] {
    K_DEV,
    K_REG,
    K_HI,
    K_LO
  } byte_kind_t;

  function automatic logic [15:0] reg_default(input int k, input logic [15:0] id);
    logic [7:0] kb;
    kb = 8'(k);
    if (k == 0) return id;
    return {kb, ~kb};
  endfunction

endpackage

// File: rtl/i2c16_sync.sv
module i2c16_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RESET_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c16_regbank.sv
module i2c16_regbank
  import i2c16_pkg::*;
#(
  parameter int                  NUM_REGS = 8,
  parameter logic [NUM_REGS-1:0] RO_MASK  = '1,
  parameter logic [15:0]         ID_VALUE = 16'h1801
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [7:0]               waddr,
  input  logic [15:0]              wdata,
  input  logic [7:0]               raddr,
  output logic [15:0]              rdata,
  output logic [16*NUM_REGS-1:0]   cfg_o
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [15:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
    if (RO_MASK[g]) begin : g_ro
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs[g] <= reg_default(g, ID_VALUE);
        else        regs[g] <= reg_default(g, ID_VALUE);
      end
    end else begin : g_rw
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        regs[g] <= reg_default(g, ID_VALUE);
        else if (we && waddr == 8'(g))     regs[g] <= wdata;
      end
    end
    assign cfg_o[16*g +: 16] = regs[g];
  end

  always_comb begin
    if (int'(raddr) < NUM_REGS) rdata = regs[raddr[IDX_W-1:0]];
    else                        rdata = 16'h0000;
  end
endmodule

// File: rtl/i2c16_link.sv
module i2c16_link
  import i2c16_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h5D
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sda_s,
  input  logic        scl_rise,
  input  logic        scl_fall,
  input  logic        start_ev,
  input  logic        stop_ev,
  input  logic [15:0] rdata,
  output logic [7:0]  ptr,
  output logic        we,
  output logic [7:0]  waddr,
  output logic [15:0] wdata,
  output logic        sda_oe
);
  link_st_t   st;
  byte_kind_t kind;
  logic [3:0] bitcnt;
  logic [7:0] shreg, hi_q, txsh;
  logic [15:0] rd_word;
  logic       rd_mode, tx_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;   kind <= K_DEV;  bitcnt <= '0;
      shreg <= '0;     hi_q <= '0;     txsh <= '0;
      rd_word <= '0;   rd_mode <= 1'b0; tx_lo <= 1'b0;
      ptr <= '0;       we <= 1'b0;     waddr <= '0;
      wdata <= '0;     sda_oe <= 1'b0;
    end else begin
      we <= 1'b0;
      if (start_ev) begin
        st <= ST_RX;  kind <= K_DEV;  bitcnt <= '0;
        sda_oe <= 1'b0;  rd_mode <= 1'b0;
      end else if (stop_ev) begin
        st <= ST_IDLE;  sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              case (kind)
                K_DEV: begin
                  if (shreg[7:1] == DEV_ADDR) begin
                    st <= ST_ACK;  sda_oe <= 1'b1;
                    rd_mode <= shreg[0];  kind <= K_REG;
                  end else begin
                    st <= ST_IDLE;
                  end
                end
                K_REG: begin
                  ptr <= shreg;  st <= ST_ACK;  sda_oe <= 1'b1;  kind <= K_HI;
                end
                K_HI: begin
                  hi_q <= shreg;  st <= ST_ACK;  sda_oe <= 1'b1;  kind <= K_LO;
                end
                default: begin
                  we <= 1'b1;  waddr <= ptr;  wdata <= {hi_q, shreg};
                  ptr <= ptr + 8'd1;
                  st <= ST_ACK;  sda_oe <= 1'b1;  kind <= K_HI;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rd_mode) begin
                st <= ST_TX;  rd_word <= rdata;  txsh <= rdata[15:8];
                tx_lo <= 1'b0;  sda_oe <= ~rdata[15];
              end else begin
                st <= ST_RX;  sda_oe <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;  st <= ST_MACK;
                if (tx_lo) ptr <= ptr + 8'd1;
              end else begin
                txsh   <= {txsh[6:0], 1'b0};
                sda_oe <= ~txsh[6];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise && sda_s) begin
              st <= ST_IDLE;
            end else if (scl_fall) begin
              st <= ST_TX;  bitcnt <= '0;
              if (!tx_lo) begin
                txsh <= rd_word[7:0];  sda_oe <= ~rd_word[7];  tx_lo <= 1'b1;
              end else begin
                rd_word <= rdata;  txsh <= rdata[15:8];
                sda_oe <= ~rdata[15];  tx_lo <= 1'b0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c16_regslave.sv
module i2c16_regslave
  import i2c16_pkg::*;
#(
  parameter logic [6:0]          DEV_ADDR    = 7'h5D,
  parameter int                  NUM_REGS    = 8,
  parameter logic [NUM_REGS-1:0] RO_MASK     = NUM_REGS'(3),
  parameter logic [15:0]         ID_VALUE    = 16'h1801,
  parameter int                  SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe,
  output logic [16*NUM_REGS-1:0] cfg_o
);
  logic scl_s, sda_s, scl_q, sda_q;
  logic scl_rise, scl_fall, start_ev, stop_ev;
  logic we;
  logic [7:0]  ptr, waddr;
  logic [15:0] wdata, rdata;

  i2c16_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
  i2c16_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;  sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;  sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

  i2c16_link #(.DEV_ADDR(DEV_ADDR)) u_link (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .rdata(rdata), .ptr(ptr), .we(we), .waddr(waddr),
    .wdata(wdata), .sda_oe(sda_oe));

  i2c16_regbank #(.NUM_REGS(NUM_REGS), .RO_MASK(RO_MASK), .ID_VALUE(ID_VALUE)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(ptr), .rdata(rdata), .cfg_o(cfg_o));
endmodule

// File: rtl/i2c16_regslave_chk.sv
module i2c16_regslave_chk #(
  parameter logic [15:0] ID_VALUE = 16'h1801
) (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_s,
  input logic        start_ev,
  input logic        stop_ev,
  input logic        sda_oe,
  input logic        we,
  input logic [15:0] id_word
);
  // R11: the data line output moves only while the sampled clock is low
  p_oe_clock_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  // R1: a start always frees the data line
  p_start_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !sda_oe);

  // R9: a stop always frees the data line
  p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);

  // R5: the identification word never departs from its value
  p_id_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    id_word == ID_VALUE);

  // R4: a word is committed by a single-cycle strobe
  p_write_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> !we);
endmodule

bind i2c16_regslave i2c16_regslave_chk #(.ID_VALUE(ID_VALUE)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_ev(start_ev),
  .stop_ev(stop_ev), .sda_oe(sda_oe), .we(we), .id_word(cfg_o[15:0]));

// File: tb/sim_i2c16_regslave.sv
`timescale 1ns/1ps
module sim_i2c16_regslave;
  localparam int NREG = 8;
  localparam int H = 10;
  localparam logic [6:0] DEV = 7'h5D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [16*NREG-1:0] cfg_o;
  logic sda_line;

  int n_chk = 0;
  int n_fail = 0;
  int viol = 0;
  bit done = 1'b0;
  logic oe_prev = 1'b0;
  logic [15:0] rbuf [4];

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c16_regslave u0 (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
                     .sda_oe(sda_oe), .cfg_o(cfg_o));

  always @(negedge clk) begin
    if (rst_n && sda_oe !== oe_prev && scl_m) viol++;
    oe_prev <= sda_oe;
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] word(input int k);
    return cfg_o[16*k +: 16];
  endfunction

  task automatic m_start();
    sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H); sda_m = 1'b0; wt(H); scl_m = 1'b0; wt(2);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; wt(H); scl_m = 1'b1; wt(H); sda_m = 1'b1; wt(H);
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(H); scl_m = 1'b1; wt(H); scl_m = 1'b0; wt(2);
    end
    sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H/2);
    ack = !sda_line;
    wt(H/2); scl_m = 1'b0; wt(2);
  endtask

  task automatic rbyte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(H); scl_m = 1'b1; wt(H/2); b[i] = sda_line; wt(H/2); scl_m = 1'b0; wt(2);
    end
    sda_m = give_ack ? 1'b0 : 1'b1;
    wt(H); scl_m = 1'b1; wt(H); scl_m = 1'b0; wt(2);
    sda_m = 1'b1;
  endtask

  // writes n words from the given values starting at register r; returns AND of all acks
  task automatic wr_seq(input logic [7:0] r, input int n, input logic [15:0] d0,
                        input logic [15:0] d1, output bit all_ack);
    bit a;
    all_ack = 1'b1;
    m_start();
    wbyte({DEV, 1'b0}, a); all_ack &= a;
    wbyte(r, a); all_ack &= a;
    for (int w = 0; w < n; w++) begin
      logic [15:0] d = (w == 0) ? d0 : d1;
      wbyte(d[15:8], a); all_ack &= a;
      wbyte(d[7:0], a);  all_ack &= a;
    end
    m_stop();
  endtask

  task automatic rd_seq(input logic [7:0] r, input int n);
    bit a;
    logic [7:0] hb, lb;
    m_start();
    wbyte({DEV, 1'b0}, a);
    wbyte(r, a);
    m_start();
    wbyte({DEV, 1'b1}, a);
    chk(a, "R6 read address ack", 16'(a), 16'h1);
    for (int w = 0; w < n; w++) begin
      rbyte(1'b1, hb);
      rbyte(w != n - 1, lb);
      rbuf[w] = {hb, lb};
    end
    // R8: after the final not-acknowledge the line stays released through a clock pulse
    wt(H); scl_m = 1'b1; wt(H/2);
    chk(sda_oe == 1'b0 && sda_line == 1'b1, "R8 line released after nack", 16'(sda_oe), 16'h0);
    wt(H/2); scl_m = 1'b0; wt(2);
    m_stop();
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R10 reset line released", 16'(sda_oe), 16'h0);
    chk(word(0) == 16'h1801, "R10 reset id word", word(0), 16'h1801);
    chk(word(2) == 16'h02FD, "R10 reset default reg2", word(2), 16'h02FD);
    chk(word(7) == 16'h07F8, "R10 reset default reg7", word(7), 16'h07F8);
  endtask

  task automatic t_single_write();
    bit ok;
    wr_seq(8'd2, 1, 16'hA55A, 16'h0, ok);
    chk(ok, "R3 every byte acknowledged", 16'(ok), 16'h1);
    chk(word(2) == 16'hA55A, "R4 word written", word(2), 16'hA55A);
  endtask

  task automatic t_seq_write();
    bit ok;
    wr_seq(8'd3, 2, 16'h3C3C, 16'h4D4D, ok);
    chk(word(3) == 16'h3C3C, "R7 first of burst", word(3), 16'h3C3C);
    chk(word(4) == 16'h4D4D, "R7 pointer advanced on write", word(4), 16'h4D4D);
  endtask

  task automatic t_read_only();
    bit ok;
    wr_seq(8'd0, 2, 16'hFFFF, 16'h0000, ok);
    chk(ok, "R5 read-only write still acked", 16'(ok), 16'h1);
    chk(word(0) == 16'h1801, "R5 id unchanged", word(0), 16'h1801);
    chk(word(1) == 16'h01FE, "R5 reg1 unchanged", word(1), 16'h01FE);
    rd_seq(8'd0, 2);
    chk(rbuf[0] == 16'h1801, "R5 id read back", rbuf[0], 16'h1801);
    chk(rbuf[1] == 16'h01FE, "R5 reg1 read back", rbuf[1], 16'h01FE);
  endtask

  task automatic t_read();
    rd_seq(8'd2, 1);
    chk(rbuf[0] == 16'hA55A, "R6 single word read", rbuf[0], 16'hA55A);
    rd_seq(8'd3, 2);
    chk(rbuf[0] == 16'h3C3C, "R6 burst first word", rbuf[0], 16'h3C3C);
    chk(rbuf[1] == 16'h4D4D, "R7 pointer advanced on read", rbuf[1], 16'h4D4D);
  endtask

  task automatic t_wrong_addr();
    bit a1, a2;
    m_start();
    wbyte({7'h22, 1'b0}, a1);
    wbyte(8'd2, a2);
    m_stop();
    chk(!a1, "R2 foreign address not acked", 16'(a1), 16'h0);
    chk(!a2, "R2 later byte not acked", 16'(a2), 16'h0);
    chk(word(2) == 16'hA55A, "R2 nothing written", word(2), 16'hA55A);
  endtask

  task automatic t_restart();
    bit a, ok;
    m_start();
    wbyte({DEV, 1'b0}, a);
    wbyte(8'd5, a);
    wbyte(8'h11, a);
    m_start();
    ok = 1'b1;
    wbyte({DEV, 1'b0}, a); ok &= a;
    wbyte(8'd6, a); ok &= a;
    wbyte(8'h12, a); ok &= a;
    wbyte(8'h34, a); ok &= a;
    m_stop();
    chk(ok, "R1 acks after restart", 16'(ok), 16'h1);
    chk(word(5) == 16'h05FA, "R1 partial word dropped", word(5), 16'h05FA);
    chk(word(6) == 16'h1234, "R1 new transaction written", word(6), 16'h1234);
  endtask

  task automatic t_stop_mid();
    bit a;
    m_start();
    wbyte({DEV, 1'b0}, a);
    wbyte(8'd7, a);
    wbyte(8'h99, a);
    m_stop();
    chk(sda_oe == 1'b0, "R9 released after stop", 16'(sda_oe), 16'h0);
    chk(word(7) == 16'h07F8, "R9 cut word not written", word(7), 16'h07F8);
  endtask

  task automatic t_out_of_range();
    bit ok;
    wr_seq(8'h20, 1, 16'hBEEF, 16'h0, ok);
    rd_seq(8'h20, 1);
    chk(rbuf[0] == 16'h0000, "R10 out of range reads zero", rbuf[0], 16'h0000);
    chk(word(7) == 16'h07F8, "R10 bank untouched", word(7), 16'h07F8);
  endtask

  initial begin
    wt(5);
    rst_n = 1'b1;
    wt(5);
    t_reset();
    t_single_write();
    t_seq_write();
    t_read_only();
    t_read();
    t_wrong_addr();
    t_restart();
    t_stop_mid();
    t_out_of_range();
    chk(viol == 0, "R11 line moved while clock high", 16'(viol), 16'h0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule